// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment and an offset into a linear address. It serves two addressing modes. The choice comes from a one-bit mode flag that tracks bit 0 of a control register and is held inside the block.

In real mode, the 16-bit segment value is multiplied by sixteen and added to the low 16 bits of the offset. The sum wraps within a 20-bit (1 MB) space. In protected mode, a cached 32-bit segment base is added to a full 32-bit offset, and the sum wraps within 4 GB. In this mode the offset is also checked against the cached 20-bit segment limit. The granularity flag scales that limit either in bytes or in 4 KB pages. An offset past the limit gives a fault and no access.

Each request gives one registered result one cycle later.

Top module: `lagen_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `acc_valid`, `acc_fault` and `lin_addr` are 0. The mode flag resets to 0, which is real mode.
- R2: In real mode, a request gives `lin_addr = ({12'b0, seg_sel, 4'b0} + offset[15:0]) mod 2^20`, with bits 31..20 equal to 0.
- R3: In real mode, `offset[31:16]`, `seg_base`, `seg_limit` and `seg_gran` have no effect, and `acc_fault` never rises.
- R4: In protected mode, an in-limit request gives `lin_addr = (seg_base + offset) mod 2^32`.
- R5: With `seg_gran` = 0, the effective limit is `seg_limit` zero-extended to 32 bits. An offset equal to it is accepted, and an offset one above it faults.
- R6: With `seg_gran` = 1, the effective limit is `{seg_limit, 12'hFFF}`. Accept and fault follow the same rule as in R5.
- R7: A faulting request raises `acc_fault` with `acc_valid` = 0 and `lin_addr` = 0. `acc_valid` and `acc_fault` are never high together.
- R8: When `ctl_we` = 1, the mode flag takes `ctl_pe` at that clock edge. A request in the same cycle still uses the old mode.
- R9: Results appear exactly one cycle after `req`. A cycle with `req` = 0 gives `acc_valid` = 0, `acc_fault` = 0 and `lin_addr` = 0 on the next cycle.
- R10: With base 0, limit 20'hFFFFF and `seg_gran` = 1 (a flat segment), `lin_addr` equals `offset` for any offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the mode flag |
| ctl_pe | input | 1 | New mode value: 0 real, 1 protected |
| req | input | 1 | Translation request |
| seg_sel | input | 16 | Segment register value (used in real mode) |
| offset | input | 32 | Offset within the segment |
| seg_base | input | 32 | Cached segment base (protected mode) |
| seg_limit | input | 20 | Cached segment limit (protected mode) |
| seg_gran | input | 1 | Limit granularity: 0 bytes, 1 4 KB pages |
| lin_addr | output | 32 | Registered linear address |
| acc_valid | output | 1 | Registered: access accepted |
| acc_fault | output | 1 | Registered: offset beyond the limit |

## Verification
A mode write and a request can fall in the same cycle. The request must then be translated under the old mode, while the new mode governs the following request. The bench provokes this on purpose in both directions: it switches into protected mode with a real-mode request that carries high offset bits and a zero limit, and it switches out again later. The random phase also mixes mode writes into requests. A bench model tracks the mode and updates it only after computing the expected result, so the test judges whether the result follows the old mode.

// File: rtl/lagen_pkg.sv
package lagen_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEG_W   = 16;
  localparam int SEG_SH  = 4;
  localparam int REAL_AW = SEG_W + SEG_SH;
  localparam int LIM_W   = 20;
  localparam int PAGE_SH = ADDR_W - LIM_W;

  typedef enum logic {MODE_REAL = 1'b0, MODE_PROT = 1'b1} addr_mode_e;
endpackage

// File: rtl/lagen_real.sv
module lagen_real #(
  parameter int SEG_W   = lagen_pkg::SEG_W,
  parameter int SEG_SH  = lagen_pkg::SEG_SH,
  parameter int ADDR_W  = lagen_pkg::ADDR_W,
  localparam int REAL_AW = SEG_W + SEG_SH
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [ADDR_W-1:0] off,
  output logic [ADDR_W-1:0] addr
);
  logic [REAL_AW-1:0] seg_sh;
  logic [REAL_AW-1:0] sum;

  assign seg_sh = {seg, {SEG_SH{1'b0}}};
  assign sum    = seg_sh + REAL_AW'(off[SEG_W-1:0]);
  assign addr   = ADDR_W'(sum);
endmodule

// File: rtl/lagen_prot.sv
module lagen_prot #(
  parameter int ADDR_W  = lagen_pkg::ADDR_W,
  parameter int LIM_W   = lagen_pkg::LIM_W,
  localparam int PAGE_SH = ADDR_W - LIM_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] off,
  input  logic [LIM_W-1:0]  lim,
  input  logic              gran,
  output logic [ADDR_W-1:0] addr,
  output logic              over
);
  logic [ADDR_W-1:0] eff_lim;

  always_comb begin
    if (gran) eff_lim = {lim, {PAGE_SH{1'b1}}};
    else      eff_lim = ADDR_W'(lim);
  end

  assign over = off > eff_lim;
  assign addr = base + off;

  // R6: a page-scaled offset whose page index fits the limit is always in range
  always_comb begin
    if (gran && (off[ADDR_W-1:PAGE_SH] <= lim))
      a_r6_page_fit: assert (!over);
  end

  // R5: a byte-granular offset with bits above the limit width must be out of range
  always_comb begin
    if (!gran && (off[ADDR_W-1:LIM_W] != '0))
      a_r5_byte_over: assert (over);
  end
endmodule

// File: rtl/lagen_top.sv
module lagen_top #(
  parameter int ADDR_W = lagen_pkg::ADDR_W,
  parameter int SEG_W  = lagen_pkg::SEG_W,
  parameter int SEG_SH = lagen_pkg::SEG_SH,
  parameter int LIM_W  = lagen_pkg::LIM_W,
  localparam int REAL_AW = SEG_W + SEG_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_pe,
  input  logic              req,
  input  logic [SEG_W-1:0]  seg_sel,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [LIM_W-1:0]  seg_limit,
  input  logic              seg_gran,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              acc_valid,
  output logic              acc_fault
);
  import lagen_pkg::*;

  addr_mode_e        mode_q;
  logic [ADDR_W-1:0] real_addr;
  logic [ADDR_W-1:0] prot_addr;
  logic              prot_over;
  logic              take_fault;
  logic              take_ok;
  logic [ADDR_W-1:0] sel_addr;

  lagen_real #(.SEG_W(SEG_W), .SEG_SH(SEG_SH), .ADDR_W(ADDR_W)) u_real (
    .seg  (seg_sel),
    .off  (offset),
    .addr (real_addr)
  );

  lagen_prot #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_prot (
    .base (seg_base),
    .off  (offset),
    .lim  (seg_limit),
    .gran (seg_gran),
    .addr (prot_addr),
    .over (prot_over)
  );

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_REAL;
    else if (ctl_we) mode_q <= addr_mode_e'(ctl_pe);
  end

  assign take_fault = req && (mode_q == MODE_PROT) && prot_over;
  assign take_ok    = req && !take_fault;
  assign sel_addr   = (mode_q == MODE_PROT) ? prot_addr : real_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_fault <= 1'b0;
      lin_addr  <= '0;
    end else begin
      acc_valid <= take_ok;
      acc_fault <= take_fault;
      lin_addr  <= take_ok ? sel_addr : '0;
    end
  end

  // R7: accept and fault are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_fault));

  // R9: no request, no result on the next cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!acc_valid && !acc_fault && lin_addr == '0));

  // R3: real-mode requests never fault
  a_r3_real_nofault: assert property (@(posedge clk) disable iff (rst)
    (req && mode_q == MODE_REAL) |=> !acc_fault);

  // R2: real-mode results stay inside the 20-bit space
  a_r2_real_range: assert property (@(posedge clk) disable iff (rst)
    (req && mode_q == MODE_REAL) |=> (lin_addr[ADDR_W-1:REAL_AW] == '0));

  // R8: a mode write lands on the next cycle
  a_r8_mode_load: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (mode_q == addr_mode_e'($past(ctl_pe))));
endmodule

// File: tb/lagen_top_bench.sv
module lagen_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0, ctl_pe = 1'b0, req = 1'b0;
  logic [15:0] seg_sel = '0;
  logic [31:0] offset = '0, seg_base = '0;
  logic [19:0] seg_limit = '0;
  logic        seg_gran = 1'b0;
  logic [31:0] lin_addr;
  logic        acc_valid, acc_fault;

  int checks = 0;
  int errors = 0;
  bit mdl_pm = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lagen_top u_lagen_top (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_pe(ctl_pe), .req(req),
    .seg_sel(seg_sel), .offset(offset), .seg_base(seg_base),
    .seg_limit(seg_limit), .seg_gran(seg_gran),
    .lin_addr(lin_addr), .acc_valid(acc_valid), .acc_fault(acc_fault)
  );

  function automatic logic [31:0] exp_addr(bit pm, bit rq, logic [15:0] s,
      logic [31:0] o, logic [31:0] b, logic [19:0] l, bit g);
    logic [31:0] r;
    if (!rq) return 32'h0;
    if (!pm) begin
      r = ({12'h0, s, 4'h0} + {16'h0, o[15:0]}) & 32'h000F_FFFF;
      return r;
    end
    if (exp_fault(pm, rq, o, l, g)) return 32'h0;
    return b + o;
  endfunction

  function automatic bit exp_fault(bit pm, bit rq, logic [31:0] o,
      logic [19:0] l, bit g);
    logic [31:0] lim32;
    if (!rq || !pm) return 1'b0;
    lim32 = g ? {l, 12'hFFF} : {12'h0, l};
    return o > lim32;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(bit we, bit pe, bit rq, logic [15:0] s, logic [31:0] o,
      logic [31:0] b, logic [19:0] l, bit g, string tag);
    logic [31:0] ea;
    bit ef;
    ea = exp_addr(mdl_pm, rq, s, o, b, l, g);
    ef = exp_fault(mdl_pm, rq, o, l, g);
    ctl_we = we; ctl_pe = pe; req = rq;
    seg_sel = s; offset = o; seg_base = b; seg_limit = l; seg_gran = g;
    @(negedge clk);
    ctl_we = 1'b0; req = 1'b0;
    chk({tag, " addr"},  lin_addr, ea);
    chk({tag, " valid"}, {31'h0, acc_valid}, {31'h0, rq && !ef});
    chk({tag, " fault"}, {31'h0, acc_fault}, {31'h0, ef});
    if (we) mdl_pm = pe;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk("R1 reset addr",  lin_addr, 32'h0);
    chk("R1 reset valid", {31'h0, acc_valid}, 32'h0);
    chk("R1 reset fault", {31'h0, acc_fault}, 32'h0);
    rst = 1'b0;
    // R1 / R2: starts in real mode
    op(0, 0, 1, 16'h1234, 32'h0000_5678, 32'h0, 20'h0, 0, "R1 R2 real start");
    // R2: wrap within 20 bits
    op(0, 0, 1, 16'hFFFF, 32'h0000_FFFF, 32'h0, 20'h0, 0, "R2 real wrap");
    // R3: upper offset and descriptor fields ignored
    op(0, 0, 1, 16'h0000, 32'hABCD_0010, 32'h5555_0000, 20'h0, 1, "R3 real ignore");
    // R9: idle cycle
    op(0, 0, 0, 16'h1111, 32'h1111, 32'h0, 20'h0, 0, "R9 idle");
    // R8: mode write with a same-cycle request uses the old mode
    op(1, 1, 1, 16'h0100, 32'hFFFF_0004, 32'h0, 20'h0, 0, "R8 old mode");
    op(0, 0, 1, 16'h0100, 32'h0000_0004, 32'h1000_0000, 20'h000FF, 0, "R8 new mode");
    // R5: byte limit boundary
    op(0, 0, 1, 16'h0, 32'h0000_0FFF, 32'h0002_0000, 20'h00FFF, 0, "R5 at limit");
    op(0, 0, 1, 16'h0, 32'h0000_1000, 32'h0002_0000, 20'h00FFF, 0, "R5 R7 past limit");
    // R6: page limit boundary
    op(0, 0, 1, 16'h0, 32'h0000_2FFF, 32'h0040_0000, 20'h00002, 1, "R6 at limit");
    op(0, 0, 1, 16'h0, 32'h0000_3000, 32'h0040_0000, 20'h00002, 1, "R6 R7 past limit");
    // R4: 32-bit wrap
    op(0, 0, 1, 16'h0, 32'h0000_2000, 32'hFFFF_F000, 20'hFFFFF, 1, "R4 wrap");
    // R10: flat segment
    op(0, 0, 1, 16'h0, 32'hDEAD_BEEF, 32'h0, 20'hFFFFF, 1, "R10 flat");
    op(0, 0, 1, 16'h0, 32'hFFFF_FFFF, 32'h0, 20'hFFFFF, 1, "R10 flat top");
    // R9: idle in protected mode
    op(0, 0, 0, 16'h0, 32'hFFFF_FFFF, 32'h0, 20'h0, 0, "R9 idle prot");
    // R8: leave protected mode with a same-cycle faulting request
    op(1, 0, 1, 16'h0, 32'h0000_0100, 32'h0, 20'h0000F, 0, "R8 R7 leave");
    op(0, 0, 1, 16'h0ABC, 32'h0000_0100, 32'h0, 20'h0000F, 0, "R8 R3 back real");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      bit we, pe, rq, g;
      logic [31:0] o, b;
      logic [19:0] l;
      string tag;
      we = ($urandom % 8) == 0;
      pe = $urandom % 2;
      rq = ($urandom % 6) != 0;
      g  = $urandom % 2;
      l  = 20'($urandom);
      b  = $urandom;
      o  = ($urandom % 2) ? $urandom : {($urandom % 2) ? l : l + 20'h1, 12'($urandom)};
      if ($urandom % 4 == 0) o = g ? {l, 12'hFFF} + 32'(i % 2) : {12'h0, l} + 32'(i % 2);
      tag = !rq ? "R9 rand" : (!mdl_pm ? "R2 rand" :
            (exp_fault(1, 1, o, l, g) ? "R7 rand" : (g ? "R6 R4 rand" : "R5 R4 rand")));
      op(we, pe, rq, 16'($urandom), o, b, l, g, tag);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule